// File: doc/BRIEF.md
# Touch Persistence Qualifier

This block turns a noisy touch-detect level into an alarm that fires only when contact lasts well beyond a set time. A 14-bit binary counter, advanced by a single-cycle oscillator tick enable, keeps wiping itself back to zero early in its count while nothing touches the pad. A one-bit touch flag is refreshed from the (synchronized) pad level once per rising edge of a mid-order counter bit. While that flag reports contact, the early wipe is suppressed and the counter can climb into its top three bits.

Once any of the top three bits is set, the wipe stays suppressed whatever the flag says. The alarm output is then high and a square-wave tone, taken from a low counter bit, is gated through. The alarm therefore lasts until the counter wraps from its all-ones value back to zero. After the wrap the normal wipe behaviour returns. A brief touch or a glitch moves the counter only a short way before the next wipe, so no alarm results.

Top module: `touch_persist_qual`

## Requirements
- R1: A synchronous active-high reset makes count_o 0, touch_flag_o 1, alarm_o 0 and tone_o 0 at the next clock edge.
- R2: When no wipe is due, count_o rises by one on the edge after a cycle with tick_i high, and holds after a cycle with tick_i low.
- R3: The count wraps from 16383 to 0 on a tick.
- R4: When count bit 7 is 1, touch_flag_o is 1 and count bits 13..11 are all 0, count_o becomes 0 on the next edge, whether tick_i is high or low.
- R5: touch_flag_o takes a new value only on the edge after a cycle in which count bit 6 is 1 and was 0 in the cycle before. It then loads the synchronized pad level, where 1 means no contact and 0 means contact.
- R6: pad_quiet_i passes through a two-flop synchronizer. A level that appears only after the second-to-last edge before the bit-6 sample edge is not captured by that sample.
- R7: While touch_flag_o is 0, bit 7 of the count does not cause a wipe.
- R8: alarm_o is 1 exactly one cycle after any of count bits 13..11 is 1. While those bits are non-zero, no wipe occurs, so the alarm persists until the count wraps.
- R9: tone_o is count bit 3 registered together with the alarm condition, so tone_o is never 1 while alarm_o is 0.
- R10: If the flag returns to 1 before count bit 11 is set, the next cycle with bit 7 set wipes the count, and no alarm is raised.
- R11: With the pad quiet since reset and ticks every cycle, the count never exceeds 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oscillator tick enable, one cycle wide |
| pad_quiet_i | input | 1 | Raw pad level, 1 = no contact, 0 = contact |
| count_o | output | 14 | Counter value |
| touch_flag_o | output | 1 | Sampled touch flag, 0 = contact seen |
| alarm_o | output | 1 | Alarm active |
| tone_o | output | 1 | Gated alarm tone |

## Verification
The counter moves one edge after a tick, and a wipe lands one edge after the cycle in which its condition is visible. The flag updates one edge after the bit-6 rise, and a pad change needs two more edges to reach the sampler. Alarm and tone follow the counter by one more register. The bench advances a reference model on the same rising edge from the same inputs and compares every output at the falling edge, so each result is checked in the cycle it is due. Directed cases place pad edges at exact count values to probe the synchronizer boundary, the short-touch wipe at 384 and the wrap at 16383.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  parameter int CNT_W       = 14; // counter stages
  parameter int WIPE_BIT    = 7;  // bit whose high level requests a wipe
  parameter int SAMPLE_BIT  = 6;  // rising edge of this bit samples the pad
  parameter int ALARM_LO    = 11; // lowest of the alarm-range bits
  parameter int TONE_BIT    = 3;  // tone source bit
  parameter int SYNC_STAGES = 2;  // pad synchronizer depth
endpackage

// File: rtl/tpq_sync.sv
module tpq_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tpq_counter.sv
module tpq_counter #(
  parameter int W = 14,
  parameter int WIPE_BIT = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         idle_flag, // 1 = no contact sampled
  input  logic         hi_any,    // alarm range reached
  output logic [W-1:0] cnt
);
  logic wipe;

  assign wipe = cnt[WIPE_BIT] & idle_flag & ~hi_any;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wipe) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tpq_sampler.sv
module tpq_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tap,    // sampling counter bit
  input  logic pad_s,  // synchronized pad level
  output logic flag
);
  logic tap_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_d <= 1'b0;
      flag  <= 1'b1;
    end else begin
      tap_d <= tap;
      if (tap && !tap_d) flag <= pad_s;
    end
  end
endmodule

// File: rtl/tpq_alarm_out.sv
module tpq_alarm_out (
  input  logic clk,
  input  logic rst,
  input  logic hi_any,
  input  logic tone_src,
  output logic alarm,
  output logic tone
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm <= 1'b0;
      tone  <= 1'b0;
    end else begin
      alarm <= hi_any;
      tone  <= hi_any & tone_src;
    end
  end
endmodule

// File: rtl/touch_persist_qual.sv
module touch_persist_qual
  import tpq_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int WIPE_B   = WIPE_BIT,
  parameter int SAMP_B   = SAMPLE_BIT,
  parameter int ALARM_B  = ALARM_LO,
  parameter int TONE_B   = TONE_BIT,
  parameter int SYNC_N   = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         pad_quiet_i,
  output logic [W-1:0] count_o,
  output logic         touch_flag_o,
  output logic         alarm_o,
  output logic         tone_o
);
  localparam int HI_N = W - ALARM_B;

  logic pad_s;
  logic hi_any;

  assign hi_any = |count_o[W-1 -: HI_N];

  tpq_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pad_quiet_i), .q(pad_s)
  );

  tpq_sampler u_samp (
    .clk(clk), .rst(rst), .tap(count_o[SAMP_B]), .pad_s(pad_s),
    .flag(touch_flag_o)
  );

  tpq_counter #(.W(W), .WIPE_BIT(WIPE_B)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .idle_flag(touch_flag_o),
    .hi_any(hi_any), .cnt(count_o)
  );

  tpq_alarm_out u_out (
    .clk(clk), .rst(rst), .hi_any(hi_any), .tone_src(count_o[TONE_B]),
    .alarm(alarm_o), .tone(tone_o)
  );
endmodule

// File: rtl/tpq_checker.sv
module tpq_checker
  import tpq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             alarm,
  input logic             tone
);
  logic hi;
  logic wipe_due;
  assign hi = |count[CNT_W-1:ALARM_LO];
  assign wipe_due = count[WIPE_BIT] && flag && !hi;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (count == '0 && flag && !alarm && !tone)); // R1
  AST_STEP: assert property (@(posedge clk) disable iff (rst) (!wipe_due && tick) |=> count == $past(count) + 1'b1); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) (!wipe_due && !tick) |=> $stable(count)); // R2
  AST_WIPE: assert property (@(posedge clk) disable iff (rst) wipe_due |=> count == '0); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst) !(count[SAMPLE_BIT] && !$past(count[SAMPLE_BIT])) |=> $stable(flag)); // R5
  AST_ALARM_ON: assert property (@(posedge clk) disable iff (rst) hi |=> alarm); // R8
  AST_TONE_GATED: assert property (@(posedge clk) disable iff (rst) tone |-> alarm); // R9
endmodule

bind touch_persist_qual tpq_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick_i), .count(count_o),
  .flag(touch_flag_o), .alarm(alarm_o), .tone(tone_o)
);

// File: tb/touch_persist_qual_tb.sv
module touch_persist_qual_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        pad = 1'b1;
  logic [13:0] count;
  logic        flag, alarm, tone;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  touch_persist_qual u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .pad_quiet_i(pad),
    .count_o(count), .touch_flag_o(flag), .alarm_o(alarm), .tone_o(tone)
  );

  // reference model built from the requirements
  logic [13:0] m_cnt;
  logic m_s1, m_s2, m_t6, m_flag, m_al, m_tn;

  function automatic bit hi_of(input logic [13:0] c);
    return |c[13:11];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_s1 <= 1'b1; m_s2 <= 1'b1; m_t6 <= 1'b0;
      m_flag <= 1'b1; m_al <= 1'b0; m_tn <= 1'b0;
    end else begin
      m_s1 <= pad;                 // R6 stage one
      m_s2 <= m_s1;                // R6 stage two
      m_t6 <= m_cnt[6];
      if (m_cnt[6] && !m_t6) m_flag <= m_s2;                      // R5
      if (m_cnt[7] && m_flag && !hi_of(m_cnt)) m_cnt <= '0;        // R4 R7
      else if (tick) m_cnt <= m_cnt + 14'd1;                       // R2 R3
      m_al <= hi_of(m_cnt);                                        // R8
      m_tn <= hi_of(m_cnt) & m_cnt[3];                             // R9
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk("R2 count", {18'd0, count}, {18'd0, m_cnt});
      chk("R5 flag", {31'd0, flag}, {31'd0, m_flag});
      chk("R8 alarm", {31'd0, alarm}, {31'd0, m_al});
      chk("R9 tone", {31'd0, tone}, {31'd0, m_tn});
    end
  end

  task automatic wait_count(input int val);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (count == val[13:0]) return;
    end
  endtask

  initial begin
    int mx;
    bit al_seen;
    bit wrapped;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 count", {18'd0, count}, 32'd0);
    chk("R1 flag", {31'd0, flag}, 32'd1);
    chk("R1 alarm", {31'd0, alarm}, 32'd0);
    chk("R1 tone", {31'd0, tone}, 32'd0);
    rst = 1'b0;
    cmp_en = 1;

    // R11: idle with ticks every cycle stays at or below 128
    mx = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
    end
    chk("R11 max idle count", mx, 128);

    // random tick density, pad quiet
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      tick = ($urandom % 4) != 0;
    end
    @(negedge clk); tick = 1'b1;

    // R6: pad change too late for the bit-6 sample is not captured
    wait_count(63);
    pad = 1'b0;
    repeat (3) @(negedge clk);
    pad = 1'b1;
    chk("R6 late edge missed", {31'd0, flag}, 32'd1);

    // R6/R7: pad change early enough is captured, bit 7 no longer wipes
    wait_count(62);
    pad = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 early edge caught", {31'd0, flag}, 32'd0);
    wait_count(129);
    chk("R7 no wipe while touched", {18'd0, count}, 32'd129);
    pad = 1'b1;
    wait_count(0);

    // R10: short touch, wipe at 384, no alarm
    wait_count(10);
    pad = 1'b0;
    repeat (200) @(negedge clk);
    pad = 1'b1;
    mx = 0; al_seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
      if (alarm) al_seen = 1;
    end
    chk("R10 short touch peak", mx, 384);
    chk("R10 no alarm", {31'd0, al_seen}, 32'd0);

    // R8/R3: long touch raises alarm, held until wrap
    wait_count(5);
    pad = 1'b0;
    repeat (2200) @(negedge clk);
    chk("R8 alarm after long touch", {31'd0, alarm}, 32'd1);
    pad = 1'b1;
    wait_count(16383);
    chk("R8 alarm held to top", {31'd0, alarm}, 32'd1);
    @(negedge clk);
    wrapped = (count == 14'd0);
    chk("R3 wrap to zero", {31'd0, wrapped}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 alarm drops after wrap", {31'd0, alarm}, 32'd0);
    mx = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
    end
    chk("R11 idle again after alarm", mx, 128);

    // constrained random: sparse pad changes, dense ticks
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      tick = ($urandom % 8) != 0;
      if (($urandom % 300) == 0) pad = ~pad;
      if (($urandom % 5000) == 0) rst = 1'b1;
      else rst = 1'b0;
    end
    rst = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule